// File: doc/BRIEF.md
# Coherent Wide Register Readback

This block serves reads of a register that is wider than one bus access. Software reads such a register as a series of narrower subwords, and the live value can change between those accesses. The block takes a snapshot of the whole register when a trigger read happens. It then returns every later subword from that snapshot, so the subwords that software puts back together all come from the same moment.

There are two trigger modes. In self-trigger mode, a non-write access to subword 0 is the trigger. That subword is returned straight from the live value in the cycle in which the snapshot is taken, and the other subwords come from the buffer. In external-trigger mode, a read of some other register arrives on `ext_trig`, and every subword, subword 0 included, comes from the buffer. Both the buffer and the bypass path carry a presented image of the live value rather than the raw value. In that image, bits that cannot be read are forced to zero and one field stored in reversed bit order is mirrored back. The block gives one readback entry per subword and leaves the choice among them to the bus side.

Top module: `wide_reg_rdbuf`

## Requirements
- R1: A buffered subword i returns snapshot bits [(i+1)*ACC_W-1 : i*ACC_W] in bits [ACC_W-1:0] of its entry. Entry i occupies `rb_entries[i*BUS_W +: BUS_W]`.
- R2: An entry is all zero unless its bit in `sub_rd_strb` is 1 and `req_is_wr` is 0.
- R3: In self-trigger mode with more than one subword, entry 0 returns image bits [ACC_W-1:0] of the live value in the same cycle, combinationally.
- R4: The snapshot loads the image of the live value on the clock edge of a trigger event and keeps it otherwise. In self-trigger mode the trigger event is `sub_rd_strb[0]`=1 with `req_is_wr`=0. In external-trigger mode it is `ext_trig`=1. A write that strobes subword 0 is not a trigger.
- R5: Reset (`rst_n`=0, asynchronous) clears the snapshot to zero, so buffered subwords read zero until the first trigger.
- R6: Bits [BUS_W-1:ACC_W] of every entry are always zero.
- R7: Image bits that are 0 in `RD_MASK` read as zero. The default mask clears bit 2 and bits 43:40.
- R8: Over REV_LO..REV_HI (default 4..19), image bit REV_LO+k carries live bit REV_HI-k. When this field crosses a subword boundary, the bypassed subword 0 carries only its part below ACC_W. With the default parameters, live bit 19 reads at entry bit 4, and live bit 4 is absent from the bypass but appears at bit 3 of buffered subword 1.
- R9: In external-trigger mode entry 0 also comes from the snapshot. In self-trigger mode `ext_trig` has no effect.
- R10: A read of a buffered subword in the same cycle as a trigger returns the snapshot taken before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| live_val | input | REG_W | Current register contents, fields in place |
| sub_rd_strb | input | N_SUB | Per-subword access strobe |
| req_is_wr | input | 1 | Current access is a write |
| ext_trig | input | 1 | Trigger read event of another register (external mode) |
| rb_entries | output | N_SUB*BUS_W | Readback entry per subword, entry i at [i*BUS_W +: BUS_W] |

## Verification
In self-trigger mode, the snapshot load and a read of a buffered subword can happen in the same cycle, because software may strobe subword 0 together with a higher subword. The bench sets up these overlaps with directed steps and with random strobe vectors. It expects the higher subwords to carry the earlier snapshot while entry 0 shows the new live image, and it compares the result with a bench model whose buffer updates only after the edge. Writes that strobe subword 0 and `ext_trig` pulses in self mode are mixed into the same stream. These confirm that neither one disturbs the snapshot that the next read returns.

// File: rtl/wrb_pkg.sv
`timescale 1ns/1ps
package wrb_pkg;
  typedef enum logic {TRIG_SELF = 1'b0, TRIG_OTHER = 1'b1} trig_src_e;

  function automatic int subword_count(input int reg_w, input int acc_w);
    return (reg_w + acc_w - 1) / acc_w;
  endfunction
endpackage

// File: rtl/wrb_image.sv
`timescale 1ns/1ps
module wrb_image #(
  parameter int             REG_W   = 64,
  parameter logic [REG_W-1:0] RD_MASK = '1,
  parameter int             REV_LO  = 4,
  parameter int             REV_HI  = 19
) (
  input  logic [REG_W-1:0] live_val,
  output logic [REG_W-1:0] image
);
  // Mirror the reversed field in place, then zero the unreadable bits.
  function automatic logic [REG_W-1:0] present(input logic [REG_W-1:0] v);
    logic [REG_W-1:0] r;
    r = v;
    for (int k = REV_LO; k <= REV_HI; k++) r[k] = v[REV_LO + REV_HI - k];
    return r & RD_MASK;
  endfunction

  assign image = present(live_val);
endmodule

// File: rtl/wrb_snapshot.sv
`timescale 1ns/1ps
module wrb_snapshot #(
  parameter int REG_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [REG_W-1:0] din,
  output logic [REG_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/wrb_slice.sv
`timescale 1ns/1ps
module wrb_slice #(
  parameter int ACC_W = 16,
  parameter int BUS_W = 32
) (
  input  logic             strb,
  input  logic             is_wr,
  input  logic [ACC_W-1:0] src,
  output logic [BUS_W-1:0] entry
);
  logic rd_hit;
  assign rd_hit = strb && !is_wr;

  always_comb begin
    entry = '0;
    if (rd_hit) entry[ACC_W-1:0] = src;
  end
endmodule

// File: rtl/wide_reg_rdbuf.sv
`timescale 1ns/1ps
module wide_reg_rdbuf
  import wrb_pkg::*;
#(
  parameter int               REG_W     = 64,
  parameter int               ACC_W     = 16,
  parameter int               BUS_W     = 32,
  parameter trig_src_e        TRIG_MODE = TRIG_SELF,
  parameter logic [REG_W-1:0] RD_MASK   = 64'hFFFF_F0FF_FFFF_FFFB,
  parameter int               REV_LO    = 4,
  parameter int               REV_HI    = 19,
  localparam int              N_SUB     = subword_count(REG_W, ACC_W)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [REG_W-1:0]       live_val,
  input  logic [N_SUB-1:0]       sub_rd_strb,
  input  logic                   req_is_wr,
  input  logic                   ext_trig,
  output logic [N_SUB*BUS_W-1:0] rb_entries
);
  localparam bit SELF_MODE = (TRIG_MODE == TRIG_SELF);
  localparam bit PLAIN_REG = SELF_MODE && (N_SUB == 1);

  logic [REG_W-1:0] image;
  logic [REG_W-1:0] buf_q;
  logic             snap_evt;
  logic             self_evt;

  wrb_image #(.REG_W(REG_W), .RD_MASK(RD_MASK), .REV_LO(REV_LO), .REV_HI(REV_HI))
    u_image (.live_val(live_val), .image(image));

  assign self_evt = sub_rd_strb[0] && !req_is_wr;
  assign snap_evt = SELF_MODE ? (self_evt && !PLAIN_REG) : ext_trig;

  wrb_snapshot #(.REG_W(REG_W))
    u_snap (.clk(clk), .rst_n(rst_n), .load(snap_evt), .din(image), .q(buf_q));

  for (genvar g = 0; g < N_SUB; g++) begin : g_sub
    logic [ACC_W-1:0] src_word;
    if (SELF_MODE && g == 0) begin : g_bypass
      assign src_word = image[ACC_W-1:0];
    end else begin : g_buffered
      assign src_word = buf_q[g*ACC_W +: ACC_W];
    end
    wrb_slice #(.ACC_W(ACC_W), .BUS_W(BUS_W))
      u_slice (.strb(sub_rd_strb[g]), .is_wr(req_is_wr), .src(src_word),
               .entry(rb_entries[g*BUS_W +: BUS_W]));
  end
endmodule

// File: rtl/wrb_checker.sv
`timescale 1ns/1ps
module wrb_checker
  import wrb_pkg::*;
#(
  parameter int        REG_W     = 64,
  parameter int        ACC_W     = 16,
  parameter int        BUS_W     = 32,
  parameter trig_src_e TRIG_MODE = TRIG_SELF,
  parameter int        N_SUB     = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [N_SUB-1:0]       sub_rd_strb,
  input logic                   req_is_wr,
  input logic [N_SUB*BUS_W-1:0] rb_entries,
  input logic [REG_W-1:0]       image,
  input logic [REG_W-1:0]       buf_q,
  input logic                   snap_evt
);
  localparam bit SELF_MODE = (TRIG_MODE == TRIG_SELF);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_evt |=> $stable(buf_q));
  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    snap_evt |=> buf_q == $past(image));

  for (genvar g = 0; g < N_SUB; g++) begin : g_chk
    p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sub_rd_strb[g] || req_is_wr) |-> rb_entries[g*BUS_W +: BUS_W] == '0);
    if (BUS_W > ACC_W) begin : g_up
      p_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rb_entries[g*BUS_W+ACC_W +: BUS_W-ACC_W] == '0);
    end
    if (SELF_MODE && g == 0 && N_SUB > 1) begin : g_byp
      p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_rd_strb[0] && !req_is_wr) |-> rb_entries[ACC_W-1:0] == image[ACC_W-1:0]);
    end else if (!(SELF_MODE && g == 0)) begin : g_buf
      p_buffered_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_rd_strb[g] && !req_is_wr) |-> rb_entries[g*BUS_W +: ACC_W] == buf_q[g*ACC_W +: ACC_W]);
    end
  end
endmodule

bind wide_reg_rdbuf wrb_checker #(
  .REG_W(REG_W), .ACC_W(ACC_W), .BUS_W(BUS_W), .TRIG_MODE(TRIG_MODE), .N_SUB(N_SUB)
) u_wrb_chk (
  .clk(clk), .rst_n(rst_n), .sub_rd_strb(sub_rd_strb), .req_is_wr(req_is_wr),
  .rb_entries(rb_entries), .image(image), .buf_q(buf_q), .snap_evt(snap_evt)
);

// File: tb/test_wide_reg_rdbuf.sv
`timescale 1ns/1ps
module test_wide_reg_rdbuf;
  import wrb_pkg::*;
  localparam logic [63:0] MASK = 64'hFFFF_F0FF_FFFF_FFFB;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [63:0]  live = '0;
  logic [3:0]   strb = '0;
  logic         wr = 1'b0;
  logic         trig = 1'b0;
  logic [127:0] rb_self, rb_ext;
  logic [63:0]  mb_self = '0, mb_ext = '0;
  int           n_cmp = 0, n_bad = 0;
  bit           done = 1'b0;

  always #4 clk = ~clk;

  wide_reg_rdbuf #(.TRIG_MODE(TRIG_SELF)) i_wide_reg_rdbuf (
    .clk(clk), .rst_n(rst_n), .live_val(live), .sub_rd_strb(strb),
    .req_is_wr(wr), .ext_trig(trig), .rb_entries(rb_self));
  wide_reg_rdbuf #(.TRIG_MODE(TRIG_OTHER)) i_wide_reg_rdbuf_ext (
    .clk(clk), .rst_n(rst_n), .live_val(live), .sub_rd_strb(strb),
    .req_is_wr(wr), .ext_trig(trig), .rb_entries(rb_ext));

  // Presented image per R7/R8: bit b in 4..19 takes live bit 23-b; masked bits are zero.
  function automatic logic [63:0] m_img(input logic [63:0] v);
    logic [63:0] o = '0;
    for (int b = 0; b < 64; b++) begin
      int s = (b >= 4 && b <= 19) ? 23 - b : b;
      if (MASK[b]) o[b] = v[s];
    end
    return o;
  endfunction

  function automatic logic [127:0] m_exp(input bit self, input logic [63:0] bufv,
                                         input logic [63:0] v, input logic [3:0] s,
                                         input logic w);
    logic [127:0] o = '0;
    logic [63:0]  im = m_img(v);
    for (int i = 0; i < 4; i++)
      if (s[i] && !w) o[i*32 +: 16] = (self && i == 0) ? im[15:0] : bufv[i*16 +: 16];
    return o;
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive at the falling edge, compare mid-low-phase, update the model after the rising edge.
  task automatic step(input string tag, input logic [63:0] v, input logic [3:0] s,
                      input logic w, input logic t);
    @(negedge clk);
    live = v; strb = s; wr = w; trig = t;
    #1;
    check({tag, " self"}, rb_self, m_exp(1'b1, mb_self, v, s, w));
    check({tag, " ext"},  rb_ext,  m_exp(1'b0, mb_ext,  v, s, w));
    @(posedge clk);
    if (s[0] && !w) mb_self = m_img(v);
    if (t)          mb_ext  = m_img(v);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R5: buffered subwords read zero before any trigger
    step("R5 empty", 64'h1234_5678_9ABC_DEF0, 4'b1110, 1'b0, 1'b0);
    // R3/R10: trigger and buffered read share a cycle
    step("R3 R10 same-cycle", 64'hA5A5_0F0F_3C3C_9999, 4'b1111, 1'b0, 1'b1);
    step("R1 buffered", 64'h0, 4'b1110, 1'b0, 1'b0);
    // R4/R2: a write strobing subword 0 is not a trigger and returns zero
    step("R2 R4 write", 64'hFFFF_FFFF_FFFF_FFFF, 4'b1111, 1'b1, 1'b0);
    step("R4 hold", 64'h0, 4'b1111, 1'b0, 1'b0);
    // R7: unreadable bit 2
    step("R7 masked", 64'h0000_0000_0000_0004, 4'b0001, 1'b0, 1'b0);
    check("R7 literal", rb_self[31:0], 32'h0);
    // R8: live bit 19 lands on bit 4 of the bypass
    step("R8 rev", 64'h0000_0000_0008_0000, 4'b0001, 1'b0, 1'b0);
    check("R8 literal bit4", rb_self[31:0], 32'h0000_0010);
    // R8: live bit 4 is cut from the bypass, appears at bit 3 of subword 1
    step("R8 trunc", 64'h0000_0000_0000_0010, 4'b0001, 1'b0, 1'b0);
    check("R8 literal bypass", rb_self[31:0], 32'h0);
    step("R8 trunc buffered", 64'h0, 4'b0010, 1'b0, 1'b0);
    check("R8 literal sub1", rb_self[63:32], 32'h0000_0008);
    // R9: ext_trig alone moves only the external-mode snapshot
    step("R9 ext trig", 64'hDEAD_BEEF_CAFE_F00D, 4'b0000, 1'b0, 1'b1);
    step("R9 readback", 64'h0, 4'b1111, 1'b0, 1'b0);
    // R6 and all others: random mix
    for (int n = 0; n < 600; n++)
      step("R1 R2 R3 R4 R6 R9 R10 random", {$urandom, $urandom}, 4'($urandom),
           ($urandom % 5) == 0, ($urandom % 4) == 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule